// File: doc/BRIEF.md
# Word-Wide Bus Memory with Abort Window and Console Port

This block is a synchronous memory slave for a 32-bit processor bus. Every clock cycle in which the active-low request input is asserted, it performs one access. A read always hands back the whole aligned 32-bit word, and the processor picks out the byte or halfword it needs. A write stores a full word, or it merges one byte or one halfword into the stored word. For a narrow write, the lane is chosen from the low address bits and a big-endian input.

A parameterised address window aborts any access that falls inside it. Such an access leaves memory untouched and returns a fixed abort word. The abort is reported as a prefetch abort when the opcode-fetch input is active (low) and as a data abort otherwise. A byte write to one console address is not stored. It either emits a character strobe or, for the value 4, a halt pulse.

All results are registered. Read data, abort flags, the reserved-size flag, the character strobe and the halt pulse appear one clock after the request. The storage is a word array indexed by the address bits above bit 1, so higher address bits alias into it.

Top module: `busmem_abort`

## Requirements
- R1: A read (`wr`=0) returns the whole word at address bits above bit 1 on `rdata`, one clock after the request, whatever the size code.
- R2: A write with size code 2'b10 stores all 32 bits of `wdata`.
- R3: A write with size code 2'b00 replaces only the byte at bit offset 8*((`big_end` ? 3 : 0) XOR `addr[1:0]`), taking it from `wdata[7:0]`. All other bits stay unchanged.
- R4: A write with size code 2'b01 replaces only the halfword at bit offset 16*(`big_end` XOR `addr[1]`), taking it from `wdata[15:0]`. All other bits stay unchanged.
- R5: A write with size code 2'b11 changes no memory and pulses `rsvd_err` for one cycle.
- R6: An access with ABT_LO <= `addr` < ABT_HI changes no memory and loads ABORT_WORD into `rdata`. It pulses `pabort` when `opfetch_n` is 0 and `dabort` when `opfetch_n` is 1. Addresses just outside either bound are accessed normally.
- R7: A byte write to CON_ADDR stores nothing. A byte value of 4 pulses `halt`. Any other value pulses `chr_valid`, and `chr_data` carries the byte.
- R8: While `req_n` is 1, memory, `rdata` and all flags are left alone (flags stay 0).
- R9: Reset clears `rdata`, `chr_data` and every flag, but it does not clear memory contents.
- R10: Addresses that differ only in bits above the index range reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Memory request, active low |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| big_end | input | 1 | Big-endian lane selection |
| opfetch_n | input | 1 | 0 = opcode fetch |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read word, or abort word |
| pabort | output | 1 | Prefetch abort pulse |
| dabort | output | 1 | Data abort pulse |
| rsvd_err | output | 1 | Reserved-size write pulse |
| chr_valid | output | 1 | Console character strobe |
| chr_data | output | 8 | Console character |
| halt | output | 1 | Halt pulse |

## Verification
The same stored word is overwritten byte by byte and halfword by halfword in both endian modes. Each resulting word differs depending on which lane moved, so a swapped or mirrored offset shows up in the next read. Write data carries set upper bits, which exposes any merge that takes bits beyond the low byte or halfword. Addresses are placed on both sides of each window bound, with the opcode flag toggled, which separates prefetch aborts from data aborts and inclusive bounds from exclusive ones. The console address and an aliased address are each followed by a read of the word they would hit, which proves that nothing was stored there.

// File: rtl/busmem_abort.sv
module busmem_abort #(
  parameter int          DEPTH      = 1024,
  parameter logic [31:0] ABT_LO     = 32'h0080_0000,
  parameter logic [31:0] ABT_HI     = 32'h01A0_0000,
  parameter logic [31:0] CON_ADDR   = 32'h0300_0000,
  parameter logic [31:0] ABORT_WORD = 32'hDEAD_0BAD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_n,
  input  logic        wr,
  input  logic [1:0]  size,
  input  logic        big_end,
  input  logic        opfetch_n,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        pabort,
  output logic        dabort,
  output logic        rsvd_err,
  output logic        chr_valid,
  output logic [7:0]  chr_data,
  output logic        halt
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0]      mem [DEPTH];
  logic [IDX_W-1:0] idx;
  logic [31:0]      cur, merged;
  logic [4:0]       bsh, hsh;
  logic             in_win, is_con;

  assign idx    = addr[IDX_W+1:2];
  assign cur    = mem[idx];
  assign in_win = (addr >= ABT_LO) && (addr < ABT_HI);
  assign is_con = (addr == CON_ADDR) && (size == 2'b00);
  assign bsh    = {addr[1:0] ^ {2{big_end}}, 3'b000};
  assign hsh    = {addr[1] ^ big_end, 4'b0000};

  always_comb begin
    case (size)
      2'b00:   merged = (cur & ~(32'h0000_00FF << bsh)) | ({24'h0, wdata[7:0]} << bsh);
      2'b01:   merged = (cur & ~(32'h0000_FFFF << hsh)) | ({16'h0, wdata[15:0]} << hsh);
      default: merged = wdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!req_n && wr && !in_win && !is_con && size != 2'b11)
      mem[idx] <= merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      pabort    <= 1'b0;
      dabort    <= 1'b0;
      rsvd_err  <= 1'b0;
      chr_valid <= 1'b0;
      chr_data  <= '0;
      halt      <= 1'b0;
    end else begin
      pabort    <= 1'b0;
      dabort    <= 1'b0;
      rsvd_err  <= 1'b0;
      chr_valid <= 1'b0;
      halt      <= 1'b0;
      if (!req_n) begin
        if (in_win) begin
          rdata  <= ABORT_WORD;
          pabort <= !opfetch_n;
          dabort <= opfetch_n;
        end else if (!wr) begin
          rdata <= cur;
        end else if (is_con) begin
          if (wdata[7:0] == 8'd4) halt <= 1'b1;
          else begin
            chr_valid <= 1'b1;
            chr_data  <= wdata[7:0];
          end
        end else if (size == 2'b11) begin
          rsvd_err <= 1'b1;
        end
      end
    end
  end

  AST_ONE_ABORT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(pabort && dabort)); // R6
  AST_ABORT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (pabort || dabort) |-> rdata == ABORT_WORD); // R6
  AST_WINDOW_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && addr >= ABT_LO && addr < ABT_HI && !opfetch_n) |=> pabort); // R6
  AST_WINDOW_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && addr >= ABT_LO && addr < ABT_HI && opfetch_n) |=> dabort); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_n |=> !(pabort || dabort || rsvd_err || chr_valid || halt)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_n |=> $stable(rdata)); // R8
  AST_CON_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(chr_valid && halt)); // R7
  AST_RSVD_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && !wr) |=> !rsvd_err); // R5
endmodule

// File: tb/busmem_abort_test.sv
`timescale 1ns/1ps
module busmem_abort_test;
  localparam logic [31:0] LO  = 32'h0000_1000;
  localparam logic [31:0] HI  = 32'h0000_2000;
  localparam logic [31:0] CON = 32'h0000_3000;
  localparam logic [31:0] AW  = 32'hBAD0_BAD0;

  logic clk = 0, rst_n = 0, req_n = 1, wr = 0, big_end = 0, opfetch_n = 1;
  logic [1:0] size = 0;
  logic [31:0] addr = 0, wdata = 0, rdata;
  logic pabort, dabort, rsvd_err, chr_valid, halt;
  logic [7:0] chr_data;

  always #4 clk = ~clk;

  busmem_abort #(.DEPTH(64), .ABT_LO(LO), .ABT_HI(HI), .CON_ADDR(CON), .ABORT_WORD(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .wr(wr), .size(size), .big_end(big_end),
    .opfetch_n(opfetch_n), .addr(addr), .wdata(wdata), .rdata(rdata), .pabort(pabort),
    .dabort(dabort), .rsvd_err(rsvd_err), .chr_valid(chr_valid), .chr_data(chr_data), .halt(halt));

  typedef struct packed {
    logic [3:0]  req;
    logic        rq_n, w;
    logic [1:0]  sz;
    logic        be, of_n, chk;
    logic [31:0] a, d, exp;
    logic [4:0]  flg;   // {pabort, dabort, rsvd_err, chr_valid, halt}
    logic [7:0]  chr;
  } vec_t;

  localparam int N = 24;
  localparam vec_t VEC [N] = '{
    '{4'd2,  1'b0,1'b1,2'b10,1'b0,1'b1,1'b0, 32'h10,  32'h11223344, 32'h0,        5'b00000, 8'h00}, // R2
    '{4'd1,  1'b0,1'b0,2'b00,1'b0,1'b1,1'b1, 32'h10,  32'h0,        32'h11223344, 5'b00000, 8'h00}, // R1
    '{4'd3,  1'b0,1'b1,2'b00,1'b0,1'b1,1'b0, 32'h11,  32'hFFFFFFAB, 32'h0,        5'b00000, 8'h00}, // R3
    '{4'd3,  1'b0,1'b0,2'b01,1'b0,1'b1,1'b1, 32'h10,  32'h0,        32'h1122AB44, 5'b00000, 8'h00}, // R3
    '{4'd3,  1'b0,1'b1,2'b00,1'b1,1'b1,1'b0, 32'h11,  32'h000000CD, 32'h0,        5'b00000, 8'h00}, // R3
    '{4'd1,  1'b0,1'b0,2'b10,1'b0,1'b1,1'b1, 32'h13,  32'h0,        32'h11CDAB44, 5'b00000, 8'h00}, // R1 R3
    '{4'd4,  1'b0,1'b1,2'b01,1'b0,1'b1,1'b0, 32'h12,  32'hAAAA5566, 32'h0,        5'b00000, 8'h00}, // R4
    '{4'd4,  1'b0,1'b0,2'b00,1'b0,1'b1,1'b1, 32'h10,  32'h0,        32'h5566AB44, 5'b00000, 8'h00}, // R4
    '{4'd4,  1'b0,1'b1,2'b01,1'b1,1'b1,1'b0, 32'h12,  32'h00007788, 32'h0,        5'b00000, 8'h00}, // R4
    '{4'd4,  1'b0,1'b0,2'b00,1'b0,1'b1,1'b1, 32'h10,  32'h0,        32'h55667788, 5'b00000, 8'h00}, // R4
    '{4'd5,  1'b0,1'b1,2'b11,1'b0,1'b1,1'b0, 32'h10,  32'hFFFFFFFF, 32'h0,        5'b00100, 8'h00}, // R5
    '{4'd5,  1'b0,1'b0,2'b10,1'b0,1'b1,1'b1, 32'h10,  32'h0,        32'h55667788, 5'b00000, 8'h00}, // R5
    '{4'd2,  1'b0,1'b1,2'b10,1'b0,1'b1,1'b0, 32'hFC,  32'h12345678, 32'h0,        5'b00000, 8'h00}, // R2
    '{4'd6,  1'b0,1'b0,2'b10,1'b0,1'b0,1'b1, LO,      32'h0,        AW,           5'b10000, 8'h00}, // R6
    '{4'd6,  1'b0,1'b1,2'b10,1'b0,1'b1,1'b1, 32'h1FFC,32'h0,        AW,           5'b01000, 8'h00}, // R6
    '{4'd6,  1'b0,1'b0,2'b10,1'b0,1'b1,1'b1, 32'hFC,  32'h0,        32'h12345678, 5'b00000, 8'h00}, // R6 R10
    '{4'd6,  1'b0,1'b1,2'b10,1'b0,1'b1,1'b0, HI,      32'hCAFEF00D, 32'h0,        5'b00000, 8'h00}, // R6
    '{4'd10, 1'b0,1'b0,2'b10,1'b0,1'b1,1'b1, 32'h0,   32'h0,        32'hCAFEF00D, 5'b00000, 8'h00}, // R10
    '{4'd6,  1'b0,1'b0,2'b10,1'b0,1'b0,1'b1, 32'hFFC, 32'h0,        32'h12345678, 5'b00000, 8'h00}, // R6
    '{4'd7,  1'b0,1'b1,2'b00,1'b0,1'b1,1'b0, CON,     32'hFFFFFF41, 32'h0,        5'b00010, 8'h41}, // R7
    '{4'd7,  1'b0,1'b1,2'b00,1'b0,1'b1,1'b0, CON,     32'h00000004, 32'h0,        5'b00001, 8'h00}, // R7
    '{4'd7,  1'b0,1'b0,2'b10,1'b0,1'b1,1'b1, 32'h0,   32'h0,        32'hCAFEF00D, 5'b00000, 8'h00}, // R7
    '{4'd8,  1'b1,1'b1,2'b10,1'b0,1'b1,1'b1, 32'h0,   32'h0,        32'hCAFEF00D, 5'b00000, 8'h00}, // R8
    '{4'd8,  1'b0,1'b0,2'b10,1'b0,1'b1,1'b1, 32'h0,   32'h0,        32'hCAFEF00D, 5'b00000, 8'h00}  // R8
  };

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic rq, input logic w, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    req_n = rq; wr = w; size = sz; addr = a; wdata = d; opfetch_n = 1; big_end = 0;
    @(negedge clk);
    req_n = 1;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 rdata", rdata, 32'h0);
    check("R9 flags", {27'h0, pabort, dabort, rsvd_err, chr_valid, halt}, 32'h0);
    check("R9 chr_data", {24'h0, chr_data}, 32'h0);
    rst_n = 1;
    foreach (VEC[i]) begin
      @(negedge clk);
      req_n = VEC[i].rq_n; wr = VEC[i].w; size = VEC[i].sz; big_end = VEC[i].be;
      opfetch_n = VEC[i].of_n; addr = VEC[i].a; wdata = VEC[i].d;
      @(negedge clk);
      req_n = 1;
      check($sformatf("R%0d flags v%0d", VEC[i].req, i),
            {27'h0, pabort, dabort, rsvd_err, chr_valid, halt}, {27'h0, VEC[i].flg});
      if (VEC[i].chk)
        check($sformatf("R%0d rdata v%0d", VEC[i].req, i), rdata, VEC[i].exp);
      if (VEC[i].flg[1])
        check($sformatf("R%0d chr_data v%0d", VEC[i].req, i), {24'h0, chr_data}, {24'h0, VEC[i].chr});
    end
    // R9: reset mid-run clears outputs, keeps memory
    access(1'b0, 1'b0, 2'b10, 32'h10, 32'h0);
    check("R1 pre-reset read", rdata, 32'h55667788);
    @(negedge clk) rst_n = 0;
    @(negedge clk);
    check("R9 rdata cleared", rdata, 32'h0);
    rst_n = 1;
    access(1'b0, 1'b0, 2'b10, 32'h10, 32'h0);
    check("R9 memory kept", rdata, 32'h55667788);
    // R3 big-endian byte 0 lands in the top byte
    @(negedge clk);
    req_n = 0; wr = 1; size = 2'b00; big_end = 1; addr = 32'h10; wdata = 32'h000000EE;
    @(negedge clk);
    req_n = 1;
    access(1'b0, 1'b0, 2'b10, 32'h10, 32'h0);
    check("R3 big-endian lane 0", rdata, 32'hEE667788);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule